// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two 8-bit buses, side A and side B. Each side has a storage register that samples its own bus pins whenever that side's capture strobe is high at a system clock edge. Each direction has a selector. The selector drives the far bus either from the live value of the near bus or from the near side's stored register. Each direction also has its own output enable. The B-side enable is active high and the A-side enable is active low.

Both buses are modelled as split vectors (`*_in_i`, `*_out_o`, `*_oe_o`), so no tri-state logic exists inside the block. The value a register sees on its own pins is the block's own drive when that side is enabled, and otherwise the external input. This lets a register capture data the block itself is driving. One use is copying one bus into both registers in a single cycle. Another is driving stored data onto both buses at once.

Enabling both directions with both selectors on live data would create a bus-to-bus loop. The block flags this combination. While it holds, the live path is taken from the external inputs only.

Top module: `xrb_top`

## Requirements
- R1: After reset (`rst_ni` low, asynchronous) both storage registers hold zero.
- R2: The A register loads the A-pin value at a clock edge when `cap_a_i` is 1 and holds its value when `cap_a_i` is 0.
- R3: The B register loads the B-pin value at a clock edge when `cap_b_i` is 1 and holds its value when `cap_b_i` is 0.
- R4: `b_out_o` equals `a_in_i` when `sel_ab_i` is 0 (live). It equals the A register when `sel_ab_i` is 1 (stored).
- R5: `a_out_o` equals `b_in_i` when `sel_ba_i` is 0. It equals the B register when `sel_ba_i` is 1.
- R6: `b_oe_o` equals `en_b_i` (active high). `a_oe_o` equals the inverse of `en_a_ni` (active low).
- R7: In isolation (`en_b_i`=0, `en_a_ni`=1) both `*_oe_o` are 0, and both registers still load from `a_in_i` and `b_in_i`.
- R8: When a side is driven, its register captures the block's own drive value on that side and ignores the external input.
- R9: Consider A as input, B driven, and `sel_ab_i`=0. If both strobes are high in one cycle, both registers take the `a_in_i` value. The mirror case does the same with `b_in_i`.
- R10: `loop_err_o` is 1 exactly when both sides are enabled and both selectors are 0.
- R11: With both sides enabled and both selectors at 1, B is driven from the A register and A from the B register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_in_i | input | 8 | External value on the A bus |
| a_out_o | output | 8 | Value the block drives onto A |
| a_oe_o | output | 1 | Block drives A |
| b_in_i | input | 8 | External value on the B bus |
| b_out_o | output | 8 | Value the block drives onto B |
| b_oe_o | output | 1 | Block drives B |
| cap_a_i | input | 1 | Strobe: A register samples A pins |
| cap_b_i | input | 1 | Strobe: B register samples B pins |
| sel_ab_i | input | 1 | B drive source: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | A drive source: 0 live B, 1 stored B |
| en_b_i | input | 1 | Drive B, active high |
| en_a_ni | input | 1 | Drive A, active low |
| loop_err_o | output | 1 | Both directions live and enabled |

## Verification
Two functions can fall in the same cycle. One is a register capture. The other is the block driving the very pins that register samples, either live from the far bus or from the far register. The bench provokes this by sweeping every combination of the two strobes, the two selectors and the two enables, with changing data. It predicts each register from the resolved pin value of the previous cycle and compares it with what appears later on the far bus in stored mode. The single-cycle copy into both registers and the simultaneous stored drive in both directions are also checked as directed cases.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_A = 0;
  localparam int unsigned SIDE_B = 1;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xrb_store.sv
module xrb_store #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(d_i));
endmodule

// File: rtl/xrb_path.sv
module xrb_path #(
  parameter int unsigned WIDTH  = 8,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic             en_i,
  input  logic             sel_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] data_o,
  output logic             oe_o
);
  import xrb_pkg::*;

  src_e src;
  assign src    = src_e'(sel_i);
  assign data_o = (src == SRC_STORED) ? stored_i : live_i;

  generate
    if (OE_LOW) begin : g_oe_low
      assign oe_o = ~en_i;
    end else begin : g_oe_high
      assign oe_o = en_i;
    end
  endgenerate
endmodule

// File: rtl/xrb_guard.sv
module xrb_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_a_i,
  input  logic oe_b_i,
  input  logic sel_ab_i,
  input  logic sel_ba_i,
  output logic err_o
);
  assign err_o = oe_a_i && oe_b_i && !sel_ab_i && !sel_ba_i;

  p_err_needs_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (oe_a_i && oe_b_i));
endmodule

// File: rtl/xrb_top.sv
module xrb_top #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] b_out_o,
  output logic             b_oe_o,
  input  logic             cap_a_i,
  input  logic             cap_b_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic             en_b_i,
  input  logic             en_a_ni,
  output logic             loop_err_o
);
  import xrb_pkg::*;

  // index = side the value belongs to
  logic [NUM_SIDES-1:0][WIDTH-1:0] ext_in, drive, pin, stored;
  logic [NUM_SIDES-1:0]            oe, cap, sel, en;

  assign ext_in[SIDE_A] = a_in_i;
  assign ext_in[SIDE_B] = b_in_i;
  assign cap            = {cap_b_i, cap_a_i};
  // sel/en indexed by source side of the direction
  assign sel            = {sel_ba_i, sel_ab_i};
  assign en             = {en_a_ni, en_b_i};

  genvar s;
  generate
    for (s = 0; s < NUM_SIDES; s++) begin : g_side
      localparam int unsigned DST = NUM_SIDES - 1 - s;

      // own drive wins on driven pins, so capture sees it
      assign pin[s] = oe[s] ? drive[s] : ext_in[s];

      xrb_store #(.WIDTH(WIDTH)) u_store (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (cap[s]),
        .d_i    (pin[s]),
        .q_o    (stored[s])
      );

      // live path uses the external value only: no loop through own drive
      xrb_path #(.WIDTH(WIDTH), .OE_LOW(s == SIDE_B)) u_path (
        .en_i     (en[s]),
        .sel_i    (sel[s]),
        .live_i   (ext_in[s]),
        .stored_i (stored[s]),
        .data_o   (drive[DST]),
        .oe_o     (oe[DST])
      );
    end
  endgenerate

  xrb_guard u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oe_a_i   (oe[SIDE_A]),
    .oe_b_i   (oe[SIDE_B]),
    .sel_ab_i (sel_ab_i),
    .sel_ba_i (sel_ba_i),
    .err_o    (loop_err_o)
  );

  assign a_out_o = drive[SIDE_A];
  assign a_oe_o  = oe[SIDE_A];
  assign b_out_o = drive[SIDE_B];
  assign b_oe_o  = oe[SIDE_B];

  p_stored_both_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && b_oe_o && sel_ab_i && sel_ba_i) |->
      (b_out_o == stored[SIDE_A] && a_out_o == stored[SIDE_B]));
  p_copy_a_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_a_i && cap_b_i && b_oe_o && !a_oe_o && !sel_ab_i) |=>
      (stored[SIDE_A] == stored[SIDE_B]));
  p_iso_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_b_i && en_a_ni) |-> (!a_oe_o && !b_oe_o && !loop_err_o));
  p_driven_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_a_i && a_oe_o) |=> stored[SIDE_A] == $past(a_out_o));
endmodule

// File: tb/xrb_top_bench.sv
module xrb_top_bench;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, loop_err;
  logic         cap_a = 0, cap_b = 0, sel_ab = 0, sel_ba = 0, en_b = 0, en_a_n = 1;

  int unsigned n_chk = 0, n_err = 0;
  bit          done = 0;
  logic [W-1:0] ma = '0, mb = '0;

  always #5 clk = ~clk;

  xrb_top #(.WIDTH(W)) u_xrb_top (
    .clk_i(clk), .rst_ni(rst_n),
    .a_in_i(a_in), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe),
    .cap_a_i(cap_a), .cap_b_i(cap_b), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .en_b_i(en_b), .en_a_ni(en_a_n), .loop_err_o(loop_err)
  );

  task automatic expect_eq(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs, then model the capture edge
  task automatic step(input logic [W-1:0] ai, input logic [W-1:0] bi,
                      input logic sab, input logic sba, input logic eb, input logic ean,
                      input logic ca, input logic cb);
    logic [W-1:0] eb_out, ea_out, apin, bpin;
    @(negedge clk);
    a_in = ai; b_in = bi; sel_ab = sab; sel_ba = sba;
    en_b = eb; en_a_n = ean; cap_a = ca; cap_b = cb;
    #1;
    eb_out = sab ? ma : ai;
    ea_out = sba ? mb : bi;
    expect_eq("R4 b_out", b_out, eb_out);
    expect_eq("R5 a_out", a_out, ea_out);
    expect_eq("R6 b_oe", {7'd0, b_oe}, {7'd0, eb});
    expect_eq("R6 a_oe", {7'd0, a_oe}, {7'd0, ~ean});
    expect_eq("R10 loop_err", {7'd0, loop_err}, {7'd0, (eb && !ean && !sab && !sba)});
    apin = !ean ? ea_out : ai;
    bpin = eb ? eb_out : bi;
    @(posedge clk);
    if (ca) ma = apin;
    if (cb) mb = bpin;
  endtask

  // show both registers on the far buses without capturing
  task automatic peek(input string tag, input logic [W-1:0] exp_a, input logic [W-1:0] exp_b);
    @(negedge clk);
    sel_ab = 1; sel_ba = 1; en_b = 1; en_a_n = 0; cap_a = 0; cap_b = 0;
    #1;
    expect_eq({tag, " reg A"}, b_out, exp_a);
    expect_eq({tag, " reg B"}, a_out, exp_b);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(posedge clk);
    rst_n = 1;
    peek("R1", 8'h00, 8'h00);

    // R7 isolation load, R2/R3 load then hold
    step(8'h5A, 8'hA5, 0, 0, 0, 1, 1, 1);
    peek("R7", 8'h5A, 8'hA5);
    step(8'h11, 8'h22, 0, 0, 0, 1, 0, 0);
    peek("R2 R3 hold", 8'h5A, 8'hA5);
    step(8'h3C, 8'h00, 1, 1, 1, 1, 1, 0);
    peek("R2 load", 8'h3C, 8'hA5);
    step(8'h00, 8'h96, 0, 0, 0, 1, 0, 1);
    peek("R3 load", 8'h3C, 8'h96);

    // R8: A driven from stored B, external A differs, capture A
    step(8'hFF, 8'h00, 0, 1, 0, 0, 1, 0);
    peek("R8", 8'h96, 8'h96);

    // R9: copy A into both; mirror copies B into both
    step(8'hC3, 8'h0F, 0, 0, 1, 1, 1, 1);
    peek("R9 copy A", 8'hC3, 8'hC3);
    step(8'hF0, 8'h7E, 0, 0, 0, 0, 1, 1);
    peek("R9 copy B", 8'h7E, 8'h7E);

    // R11: stored both ways with distinct values
    step(8'h12, 8'h34, 0, 0, 0, 1, 1, 1);
    step(8'hEE, 8'hDD, 1, 1, 1, 0, 0, 0);
    expect_eq("R11 b_out", b_out, 8'h12);
    expect_eq("R11 a_out", a_out, 8'h34);

    // exhaustive control sweep with changing data
    lfsr = 8'h1D;
    for (int pass = 0; pass < 4; pass++) begin
      for (int c = 0; c < 64; c++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step(lfsr, lfsr * 8'd7 + 8'(c), c[0], c[1], c[2], c[3], c[4], c[5]);
        peek("R2 R3 R8 sweep", ma, mb);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule